// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as a count of whole seconds. A slow timebase, modelled as a one-cycle `tick_en` strobe in the single system clock domain, drives a 20-bit divider that counts down from a programmable reload value. Each time the divider passes zero, the 32-bit seconds counter advances. The counter is compared with a 32-bit alarm value, and a wrap past the top of its range is detected. Second, alarm and overflow events each latch a flag. Each flag has its own enable, and the enabled flags drive one interrupt line.

Software reaches the block through a 16-bit register bus with a combinational read path. The counter, the alarm and the reload value are only written inside a configuration window. Writes made while the window is open go to staging registers. Closing the window starts a commit, which takes three timebase ticks. During the commit a write-done status bit reads 0. At the third tick the staged halves are copied into the live registers. Because the divider can be read back, software can work out the fraction of the current second.

Top module: `secs_rtc`

## Requirements
- R1: After reset the counter reads 0, the alarm reads 0xFFFFFFFF, the reload and divider both read 0x07FFF, the control-low register reads 0x0020 (only write-done set), the enables read 0 and `irq` is low.
- R2: On each timebase tick the divider decreases by one. On a tick where it is already 0 it reloads instead and produces a second tick, so a reload of N-1 gives one second every N ticks. The divider is read at address 4 (upper 4 bits, in bits 3:0) and at address 5 (lower 16 bits).
- R3: Every second tick adds one to the seconds counter. The counter is read at address 6 (bits 31:16) and at address 7 (bits 15:0).
- R4: Writes to the staging addresses have no effect on the live values unless the configuration bit (address 0, bit 4) is 1. These addresses are 2 (reload bits 19:16), 3 (reload 15:0), 6 and 7 (counter) and 8 and 9 (alarm high and low).
- R5: Writing 0 to the configuration bit while staged writes are pending starts a commit. Write-done (address 0, bit 5) then reads 0 for the next three ticks. At the third tick the staged halves become live. A commit that loads the counter or the reload value also restarts the divider at the new reload value.
- R6: A second tick that takes the counter from 0xFFFFFFFF to 0 sets the overflow flag (address 0, bit 2).
- R7: A second tick that brings the counter to the alarm value sets the alarm flag (address 0, bit 1).
- R8: Every second tick sets the second flag (address 0, bit 0). In a write to address 0, a 0 in a flag bit clears that flag and a 1 leaves it unchanged.
- R9: `irq` is high when any flag is set together with its enable in address 1 (bit 0 second, bit 1 alarm, bit 2 overflow). Writing 0 to address 1 disables all three.
- R10: Writing 0 to the synchronised bit (address 0, bit 3) clears it, and the next timebase tick sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | One-cycle timebase tick strobe |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. A timebase tick updates the divider, the counter and the flags at the edge where `tick_en` is high. `irq` and all read data follow one edge later with no further register stage. A commit is due at the third tick after the window closes, counting only ticks. The bench drives inputs on falling edges and pulses ticks one at a time. It reads values back only after the edge that must have produced them, so each check compares against a divider and counter model advanced one tick at a time.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam logic [3:0] A_CTRL_LO = 4'd0;
  localparam logic [3:0] A_CTRL_HI = 4'd1;
  localparam logic [3:0] A_RLD_HI  = 4'd2;
  localparam logic [3:0] A_RLD_LO  = 4'd3;
  localparam logic [3:0] A_DIV_HI  = 4'd4;
  localparam logic [3:0] A_DIV_LO  = 4'd5;
  localparam logic [3:0] A_CNT_HI  = 4'd6;
  localparam logic [3:0] A_CNT_LO  = 4'd7;
  localparam logic [3:0] A_ALM_HI  = 4'd8;
  localparam logic [3:0] A_ALM_LO  = 4'd9;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_ALM  = 1;
  localparam int unsigned F_OVF  = 2;
  localparam int unsigned F_SYNC = 3;
  localparam int unsigned F_CFG  = 4;
  localparam int unsigned F_DONE = 5;

  localparam int unsigned NSLOT = 6;
  localparam int unsigned S_RHI = 0;
  localparam int unsigned S_RLO = 1;
  localparam int unsigned S_CHI = 2;
  localparam int unsigned S_CLO = 3;
  localparam int unsigned S_AHI = 4;
  localparam int unsigned S_ALO = 5;
endpackage

// File: rtl/rtc_cfg_stage.sv
module rtc_cfg_stage #(
  parameter int BUS_W        = 16,
  parameter int NSL          = 6,
  parameter int COMMIT_TICKS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_en,
  input  logic                      stage_we,
  input  logic [NSL-1:0]            stage_sel,
  input  logic [BUS_W-1:0]          wdata,
  input  logic                      cfg_exit,
  output logic                      busy,
  output logic                      apply,
  output logic [NSL-1:0]            pend,
  output logic [NSL-1:0][BUS_W-1:0] staged
);
  localparam int CW = (COMMIT_TICKS > 1) ? $clog2(COMMIT_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(COMMIT_TICKS - 1);

  logic           busy_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NSL-1:0] pend_d;

  assign apply = busy && tick_en && (cnt_q == LAST);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    pend_d = pend;
    if (apply) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      pend_d = '0;
    end else if (busy && tick_en) begin
      cnt_d = cnt_q + 1'b1;
    end else if (!busy && cfg_exit && (|pend)) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
    if (stage_we) pend_d = pend_d | stage_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      pend  <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
      pend  <= pend_d;
    end
  end

  for (genvar g = 0; g < NSL; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       staged[g] <= '0;
      else if (stage_we && stage_sel[g]) staged[g] <= wdata;
    end
  end

  p_apply_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (!busy && pend == '0));
  p_busy_has_work_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (|pend));
  p_no_stage_in_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stage_we |-> !busy);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int              BUS_W    = 16,
  parameter int              RLD_W    = 20,
  parameter logic [RLD_W-1:0] RLD_INIT = 20'h07FFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  restart,
  input  logic                  ld_hi,
  input  logic                  ld_lo,
  input  logic [RLD_W-BUS_W-1:0] hi_val,
  input  logic [BUS_W-1:0]      lo_val,
  output logic [RLD_W-1:0]      reload,
  output logic [RLD_W-1:0]      div,
  output logic                  sec_tick
);
  localparam int RH_W = RLD_W - BUS_W;

  logic [RLD_W-1:0] rld_d, div_d;

  assign rld_d[RLD_W-1:BUS_W] = ld_hi ? hi_val : reload[RLD_W-1:BUS_W];
  assign rld_d[BUS_W-1:0]     = ld_lo ? lo_val : reload[BUS_W-1:0];
  assign sec_tick = tick_en && (div == '0) && !restart;

  always_comb begin
    div_d = div;
    if (restart)              div_d = rld_d;
    else if (tick_en) begin
      if (div == '0)          div_d = reload;
      else                    div_d = div - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= RLD_INIT;
      div    <= RLD_INIT;
    end else begin
      reload <= rld_d;
      div    <= div_d;
    end
  end

  p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div <= reload);
  p_reload_on_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> div == $past(reload));
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !restart && div != '0) |=> div == $past(div) - 1'b1);
  p_load_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi || ld_lo) |-> restart);
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int BUS_W = 16,
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_tick,
  input  logic                   ld_cnt_hi,
  input  logic                   ld_cnt_lo,
  input  logic                   ld_alm_hi,
  input  logic                   ld_alm_lo,
  input  logic [CNT_W-BUS_W-1:0] cnt_hi_val,
  input  logic [BUS_W-1:0]       cnt_lo_val,
  input  logic [CNT_W-BUS_W-1:0] alm_hi_val,
  input  logic [BUS_W-1:0]       alm_lo_val,
  output logic [CNT_W-1:0]       count,
  output logic [CNT_W-1:0]       alarm,
  output logic                   ev_alarm,
  output logic                   ev_wrap
);
  logic [CNT_W-1:0] cnt_inc, cnt_d, alm_d;

  assign cnt_inc  = count + 1'b1;
  assign ev_alarm = sec_tick && (cnt_inc == alarm);
  assign ev_wrap  = sec_tick && (&count);

  always_comb begin
    cnt_d = count;
    if (ld_cnt_hi || ld_cnt_lo) begin
      cnt_d[CNT_W-1:BUS_W] = ld_cnt_hi ? cnt_hi_val : count[CNT_W-1:BUS_W];
      cnt_d[BUS_W-1:0]     = ld_cnt_lo ? cnt_lo_val : count[BUS_W-1:0];
    end else if (sec_tick) begin
      cnt_d = cnt_inc;
    end
    alm_d = alarm;
    if (ld_alm_hi) alm_d[CNT_W-1:BUS_W] = alm_hi_val;
    if (ld_alm_lo) alm_d[BUS_W-1:0]     = alm_lo_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      alarm <= '1;
    end else begin
      count <= cnt_d;
      alarm <= alm_d;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !ld_cnt_hi && !ld_cnt_lo) |=> count == $past(count) + 1'b1);
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> count == '0);
  p_alarm_reached_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_alarm && !ld_alm_hi && !ld_alm_lo) |=> count == alarm);
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int               BUS_W        = 16,
  parameter int               RLD_W        = 20,
  parameter int               CNT_W        = 32,
  parameter int               COMMIT_TICKS = 3,
  parameter logic [RLD_W-1:0] RLD_INIT     = 20'h07FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int RH_W = RLD_W - BUS_W;
  localparam int CH_W = CNT_W - BUS_W;

  logic [1:0] rs_q;
  logic       rstc_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rstc_n = rs_q[1];

  logic             wr, wr_ctl_lo, wr_ctl_hi, cfg_exit, stage_we;
  logic [NSLOT-1:0] stage_sel, pend;
  logic [NSLOT-1:0][BUS_W-1:0] staged;
  logic             busy, apply, restart, sec_tick, ev_alarm, ev_wrap;
  logic [RLD_W-1:0] reload, div;
  logic [CNT_W-1:0] count, alarm;
  logic             cfg_q, cfg_d, sync_q, sync_d;
  logic [2:0]       flags_q, flags_d, ie_q, ie_d, ev;

  assign wr        = bus_sel && bus_wr;
  assign wr_ctl_lo = wr && (bus_addr == A_CTRL_LO);
  assign wr_ctl_hi = wr && (bus_addr == A_CTRL_HI);
  assign cfg_exit  = wr_ctl_lo && cfg_q && !bus_wdata[F_CFG];

  always_comb begin
    stage_sel = '0;
    case (bus_addr)
      A_RLD_HI: stage_sel[S_RHI] = 1'b1;
      A_RLD_LO: stage_sel[S_RLO] = 1'b1;
      A_CNT_HI: stage_sel[S_CHI] = 1'b1;
      A_CNT_LO: stage_sel[S_CLO] = 1'b1;
      A_ALM_HI: stage_sel[S_AHI] = 1'b1;
      A_ALM_LO: stage_sel[S_ALO] = 1'b1;
      default:  stage_sel = '0;
    endcase
  end
  assign stage_we = wr && cfg_q && !busy && (|stage_sel);

  rtc_cfg_stage #(.BUS_W(BUS_W), .NSL(NSLOT), .COMMIT_TICKS(COMMIT_TICKS)) u_stage (
    .clk(clk), .rst_n(rstc_n), .tick_en(tick_en), .stage_we(stage_we),
    .stage_sel(stage_sel), .wdata(bus_wdata), .cfg_exit(cfg_exit),
    .busy(busy), .apply(apply), .pend(pend), .staged(staged));

  assign restart = apply && (|pend[S_CLO:S_RHI]);

  rtc_prescaler #(.BUS_W(BUS_W), .RLD_W(RLD_W), .RLD_INIT(RLD_INIT)) u_presc (
    .clk(clk), .rst_n(rstc_n), .tick_en(tick_en), .restart(restart),
    .ld_hi(apply && pend[S_RHI]), .ld_lo(apply && pend[S_RLO]),
    .hi_val(staged[S_RHI][RH_W-1:0]), .lo_val(staged[S_RLO]),
    .reload(reload), .div(div), .sec_tick(sec_tick));

  rtc_seconds #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_secs (
    .clk(clk), .rst_n(rstc_n), .sec_tick(sec_tick),
    .ld_cnt_hi(apply && pend[S_CHI]), .ld_cnt_lo(apply && pend[S_CLO]),
    .ld_alm_hi(apply && pend[S_AHI]), .ld_alm_lo(apply && pend[S_ALO]),
    .cnt_hi_val(staged[S_CHI][CH_W-1:0]), .cnt_lo_val(staged[S_CLO]),
    .alm_hi_val(staged[S_AHI][CH_W-1:0]), .alm_lo_val(staged[S_ALO]),
    .count(count), .alarm(alarm), .ev_alarm(ev_alarm), .ev_wrap(ev_wrap));

  assign ev = {ev_wrap, ev_alarm, sec_tick};

  always_comb begin
    flags_d = (wr_ctl_lo ? (flags_q & bus_wdata[2:0]) : flags_q) | ev;
    cfg_d   = wr_ctl_lo ? bus_wdata[F_CFG] : cfg_q;
    ie_d    = wr_ctl_hi ? bus_wdata[2:0] : ie_q;
    sync_d  = sync_q;
    if (tick_en)                             sync_d = 1'b1;
    else if (wr_ctl_lo && !bus_wdata[F_SYNC]) sync_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rstc_n) begin
    if (!rstc_n) begin
      flags_q <= '0;
      cfg_q   <= 1'b0;
      sync_q  <= 1'b0;
      ie_q    <= '0;
    end else begin
      flags_q <= flags_d;
      cfg_q   <= cfg_d;
      sync_q  <= sync_d;
      ie_q    <= ie_d;
    end
  end

  assign irq = |(flags_q & ie_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL_LO: begin
        bus_rdata[2:0]    = flags_q;
        bus_rdata[F_SYNC] = sync_q;
        bus_rdata[F_CFG]  = cfg_q;
        bus_rdata[F_DONE] = !busy;
      end
      A_CTRL_HI: bus_rdata[2:0] = ie_q;
      A_RLD_HI:  bus_rdata = BUS_W'(reload[RLD_W-1:BUS_W]);
      A_RLD_LO:  bus_rdata = reload[BUS_W-1:0];
      A_DIV_HI:  bus_rdata = BUS_W'(div[RLD_W-1:BUS_W]);
      A_DIV_LO:  bus_rdata = div[BUS_W-1:0];
      A_CNT_HI:  bus_rdata = BUS_W'(count[CNT_W-1:BUS_W]);
      A_CNT_LO:  bus_rdata = count[BUS_W-1:0];
      A_ALM_HI:  bus_rdata = BUS_W'(alarm[CNT_W-1:BUS_W]);
      A_ALM_LO:  bus_rdata = alarm[BUS_W-1:0];
      default:   bus_rdata = '0;
    endcase
  end

  p_sec_flag_set_r8: assert property (@(posedge clk) disable iff (!rstc_n)
    sec_tick |=> flags_q[F_SEC]);
  p_sec_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstc_n)
    (wr_ctl_lo && !bus_wdata[F_SEC] && !sec_tick) |=> !flags_q[F_SEC]);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rstc_n)
    (ie_q == 3'b000) |-> !irq);
  p_sync_after_tick_r10: assert property (@(posedge clk) disable iff (!rstc_n)
    tick_en |=> sync_q);
endmodule

// File: tb/secs_rtc_test.sv
module secs_rtc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  secs_rtc uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd32(input logic [3:0] ahi, output logic [31:0] v);
    logic [15:0] h, l;
    rd_reg(ahi, h);
    rd_reg(ahi + 4'd1, l);
    v = {h, l};
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic commit(input logic [19:0] rld, input logic [31:0] cnt,
                        input bit with_alm, input logic [31:0] alm);
    logic [15:0] d;
    wr_reg(4'd0, 16'h001F);
    wr_reg(4'd2, {12'h0, rld[19:16]});
    wr_reg(4'd3, rld[15:0]);
    wr_reg(4'd6, cnt[31:16]);
    wr_reg(4'd7, cnt[15:0]);
    if (with_alm) begin
      wr_reg(4'd8, alm[31:16]);
      wr_reg(4'd9, alm[15:0]);
    end
    wr_reg(4'd0, 16'h000F);
    rd_reg(4'd0, d);
    chk("R5 done low after window closes", {31'h0, d[5]}, 32'h0);
    for (int i = 0; i < 3; i++) tick();
    rd_reg(4'd0, d);
    chk("R5 done high after three ticks", {31'h0, d[5]}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] v;
    logic [31:0] cexp;
    logic [19:0] dexp;
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd32(4'd6, v); chk("R1 count", v, 32'h0);
    rd32(4'd8, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
    rd32(4'd2, v); chk("R1 reload", v, 32'h0000_7FFF);
    rd32(4'd4, v); chk("R1 divider", v, 32'h0000_7FFF);
    rd_reg(4'd0, d); chk("R1 ctrl lo", {16'h0, d}, 32'h20);
    rd_reg(4'd1, d); chk("R1 ctrl hi", {16'h0, d}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R4 writes outside the window are ignored
    wr_reg(4'd7, 16'h0005);
    wr_reg(4'd9, 16'h0007);
    wr_reg(4'd3, 16'h0002);
    wr_reg(4'd0, 16'h0010);
    wr_reg(4'd0, 16'h0000);
    rd_reg(4'd0, d); chk("R4 no commit without staged writes", {31'h0, d[5]}, 32'h1);
    rd32(4'd6, v); chk("R4 count untouched", v, 32'h0);
    rd32(4'd8, v); chk("R4 alarm untouched", v, 32'hFFFF_FFFF);
    rd32(4'd2, v); chk("R4 reload untouched", v, 32'h0000_7FFF);

    // R5 commit timing, first case checked tick by tick
    wr_reg(4'd0, 16'h001F);
    wr_reg(4'd3, 16'h0003);
    wr_reg(4'd7, 16'h000A);
    wr_reg(4'd0, 16'h000F);
    tick(); tick();
    rd_reg(4'd0, d); chk("R5 still busy after two ticks", {31'h0, d[5]}, 32'h0);
    rd32(4'd6, v); chk("R5 count not yet applied", {31'h0, v == 32'hA}, 32'h0);
    tick();
    rd_reg(4'd0, d); chk("R5 done after third tick", {31'h0, d[5]}, 32'h1);
    rd32(4'd6, v); chk("R5 count applied", v, 32'hA);
    rd32(4'd4, v); chk("R5 divider restarted", v, 32'h3);

    // R2 / R3 sweep over several divide ratios
    for (int n = 1; n <= 7; n++) begin
      commit(20'(n - 1), 32'(100 * n), 1'b0, 32'h0);
      cexp = 32'(100 * n);
      dexp = 20'(n - 1);
      rd32(4'd4, v); chk("R5 divider at reload", v, {12'h0, dexp});
      rd32(4'd6, v); chk("R5 count loaded", v, cexp);
      for (int t = 0; t < 3 * n; t++) begin
        tick();
        if (dexp == 0) begin dexp = 20'(n - 1); cexp = cexp + 1; end
        else dexp = dexp - 1;
        rd32(4'd4, v); chk("R2 divider", v, {12'h0, dexp});
        rd32(4'd6, v); chk("R3 count", v, cexp);
      end
    end

    // R8 flags: write 1 keeps, write 0 clears
    wr_reg(4'd0, 16'h0008);
    rd_reg(4'd0, d); chk("R8 flags cleared", {29'h0, d[2:0]}, 32'h0);
    wr_reg(4'd0, 16'h000F);
    rd_reg(4'd0, d); chk("R8 write one does not set", {29'h0, d[2:0]}, 32'h0);
    commit(20'h1, 32'h40, 1'b0, 32'h0);
    wr_reg(4'd0, 16'h0008);
    tick(); tick();
    rd_reg(4'd0, d); chk("R8 second flag set", {31'h0, d[0]}, 32'h1);
    wr_reg(4'd0, 16'h000F);
    rd_reg(4'd0, d); chk("R8 write one keeps flag", {31'h0, d[0]}, 32'h1);

    // R9 interrupt enables
    chk("R9 irq off without enable", {31'h0, irq}, 32'h0);
    wr_reg(4'd1, 16'h0002);
    chk("R9 irq off, other enable", {31'h0, irq}, 32'h0);
    wr_reg(4'd1, 16'h0001);
    chk("R9 irq on", {31'h0, irq}, 32'h1);
    wr_reg(4'd1, 16'h0000);
    chk("R9 irq off after clearing enables", {31'h0, irq}, 32'h0);
    wr_reg(4'd1, 16'h0001);
    wr_reg(4'd0, 16'h000E);
    rd_reg(4'd0, d); chk("R8 write zero clears", {31'h0, d[0]}, 32'h0);
    chk("R9 irq drops with flag", {31'h0, irq}, 32'h0);
    wr_reg(4'd1, 16'h0000);

    // R7 alarm
    commit(20'h0, 32'd20, 1'b1, 32'd22);
    rd32(4'd8, v); chk("R7 alarm loaded", v, 32'd22);
    wr_reg(4'd0, 16'h0008);
    wr_reg(4'd1, 16'h0002);
    tick();
    rd_reg(4'd0, d); chk("R7 no alarm at 21", {31'h0, d[1]}, 32'h0);
    tick();
    rd32(4'd6, v); chk("R7 count at alarm", v, 32'd22);
    rd_reg(4'd0, d); chk("R7 alarm flag", {31'h0, d[1]}, 32'h1);
    chk("R9 alarm irq", {31'h0, irq}, 32'h1);
    tick();
    wr_reg(4'd0, 16'h0008);
    wr_reg(4'd1, 16'h0000);

    // R6 overflow
    commit(20'h0, 32'hFFFF_FFFE, 1'b1, 32'd5);
    wr_reg(4'd0, 16'h0008);
    wr_reg(4'd1, 16'h0004);
    tick();
    rd32(4'd6, v); chk("R6 count at top", v, 32'hFFFF_FFFF);
    rd_reg(4'd0, d); chk("R6 no overflow yet", {31'h0, d[2]}, 32'h0);
    tick();
    rd32(4'd6, v); chk("R6 count wrapped", v, 32'h0);
    rd_reg(4'd0, d); chk("R6 overflow flag", {31'h0, d[2]}, 32'h1);
    chk("R9 overflow irq", {31'h0, irq}, 32'h1);

    // R10 synchronised bit
    rd_reg(4'd0, d); chk("R10 sync set after ticks", {31'h0, d[3]}, 32'h1);
    wr_reg(4'd0, 16'h0007);
    rd_reg(4'd0, d); chk("R10 sync cleared", {31'h0, d[3]}, 32'h0);
    chk("R8 flags kept by sync clear", {31'h0, d[2]}, 32'h1);
    tick();
    rd_reg(4'd0, d); chk("R10 sync set by tick", {31'h0, d[3]}, 32'h1);

    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule